// File: doc/BRIEF.md
# Halfword Breakpoint Comparator Unit

This block watches the instruction fetch address of a processor core and flags a breakpoint when that address falls on a programmed halfword. A small bank of comparator slots holds the watched locations. The number of slots is a parameter, four by default. Each slot stores a word address taken from the low code region, together with a two-bit halfword selector. The selector chooses neither halfword, the lower one, the upper one or both halfwords of that word. A single global enable gates every slot at once.

Software or a debug agent programs the unit through a simple 32-bit register port. Writes are strobed and reads are combinational. One control word sits at byte offset 0x0. The slot words start at offset 0x8 and follow each other at a four-byte stride. The control word carries a must-be-one key bit, and a control write that leaves the key at zero changes nothing. The compare result is registered. One cycle after a fetch address is presented, `bp_hit` reports whether any slot matched, and `bp_hit_vec` names the lowest-numbered matching slot as a one-hot vector. Halting the core is left to the consumer of `bp_hit`.

The block has no sequencing states: both the register bank and the hit stage are plain registers updated every cycle.

Top module: `halfword_bp_unit`

## Requirements
- R1: Reading offset 0x0 returns the slot count in bits [7:4], the global enable in bit 0, and zero in bit 1 and in all other bits.
- R2: A write to offset 0x0 updates the global enable from data bit 0 only when data bit 1 is 1. With data bit 1 at 0 the write has no effect.
- R3: After reset the global enable is 0, every slot word reads 0, `bp_hit` is 0 and `bp_hit_vec` is 0.
- R4: Slot k lives at byte offset 0x8 + 4*k. Its word reads back the halfword selector in bits [31:30], the compare word address in bits [28:2] and the slot enable in bit 0. Bits 29 and 1 read as zero whatever was written.
- R5: Selector 00 never matches. Selector 01 matches only when fetch bit 1 is 0, selector 10 only when fetch bit 1 is 1, and selector 11 matches either halfword. Fetch bit 0 is ignored.
- R6: A fetch address with any of bits [31:29] set never produces a hit.
- R7: No hit is produced while the global enable is 0. A slot whose enable bit is 0 never contributes to a hit.
- R8: `bp_hit` and `bp_hit_vec` are registered. They reflect the fetch address present at the previous rising clock edge, and `bp_hit` is 1 exactly when `bp_hit_vec` is nonzero.
- R9: When several slots match at once, `bp_hit_vec` is one-hot on the lowest matching slot index.
- R10: Writes to a slot offset at or beyond the implemented count, and to offset 0x4, are ignored. Reads at those offsets return zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_wr_en | input | 1 | Register write strobe |
| cfg_addr | input | ADDR_W | Register byte offset; bits [1:0] are ignored |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Combinational read data for `cfg_addr` |
| fetch_addr | input | 32 | Instruction fetch address from the core |
| bp_hit | output | 1 | Registered breakpoint hit |
| bp_hit_vec | output | NUM_CMP | Registered one-hot index of the lowest matching slot |

## Verification
The assertions check four properties on every cycle. The hit vector is at most one-hot and always agrees with `bp_hit`. An address above the code region, or a cleared global enable, is followed by a quiet output. A keyless control write leaves the enable untouched, and the control word's key bit and count field read back correctly. Some behaviour only the bench scenarios can show: the halfword selection of each mode, the priority choice among overlapping slots, the one-cycle latency, slot readback with the dropped bits, and ignored writes to unimplemented offsets.

// File: rtl/hbp_pkg.sv
package hbp_pkg;

    localparam int CMP_WORD_W   = 27;  // compare address bits [28:2]
    localparam int CTRL_WORD_IX = 0;   // control at byte offset 0x0
    localparam int SLOT_WORD_IX = 2;   // first slot at byte offset 0x8

    typedef enum logic [1:0] {
        HW_NONE  = 2'b00,
        HW_LOWER = 2'b01,
        HW_UPPER = 2'b10,
        HW_BOTH  = 2'b11
    } hw_sel_e;

    typedef struct packed {
        hw_sel_e                 sel;
        logic [CMP_WORD_W-1:0]   word;
        logic                    en;
    } slot_cfg_t;

endpackage

// File: rtl/hbp_global_ctl.sv
module hbp_global_ctl #(
    parameter int NUM_CMP = 4
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_en,
    input  logic [31:0] wdata,
    output logic        glob_en,
    output logic [31:0] rdata
);
    localparam logic [3:0] CNT_FIELD = NUM_CMP[3:0];

    logic unused_wbits;
    assign unused_wbits = ^{wdata[31:2]};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            glob_en <= 1'b0;
        end else if (wr_en && wdata[1]) begin
            glob_en <= wdata[0];
        end
    end

    assign rdata = {24'b0, CNT_FIELD, 2'b00, 1'b0, glob_en};

endmodule

// File: rtl/hbp_slot.sv
module hbp_slot
    import hbp_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_en,
    input  logic [31:0] wdata,
    input  logic        glob_en,
    input  logic [31:0] fetch_addr,
    output logic [31:0] rdata,
    output logic        match
);
    slot_cfg_t cfg;
    logic      half_ok;
    logic      unused_bits;

    assign unused_bits = ^{wdata[29], wdata[1], fetch_addr[0]};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg <= '0;
        end else if (wr_en) begin
            cfg.sel  <= hw_sel_e'(wdata[31:30]);
            cfg.word <= wdata[28:2];
            cfg.en   <= wdata[0];
        end
    end

    assign rdata = {cfg.sel, 1'b0, cfg.word, 1'b0, cfg.en};

    always_comb begin
        unique case (cfg.sel)
            HW_LOWER: half_ok = ~fetch_addr[1];
            HW_UPPER: half_ok =  fetch_addr[1];
            HW_BOTH:  half_ok = 1'b1;
            default:  half_ok = 1'b0;
        endcase
    end

    assign match = glob_en && cfg.en && (fetch_addr[31:29] == 3'b000)
                   && (fetch_addr[28:2] == cfg.word) && half_ok;

endmodule

// File: rtl/hbp_hit_pick.sv
module hbp_hit_pick #(
    parameter int NUM_CMP = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_CMP-1:0] match,
    output logic               hit,
    output logic [NUM_CMP-1:0] hit_vec
);
    logic [NUM_CMP-1:0] lowest;

    // isolate the lowest set bit
    assign lowest = match & (~match + NUM_CMP'(1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hit     <= 1'b0;
            hit_vec <= '0;
        end else begin
            hit     <= |match;
            hit_vec <= lowest;
        end
    end

endmodule

// File: rtl/halfword_bp_unit.sv
module halfword_bp_unit
    import hbp_pkg::*;
#(
    parameter int NUM_CMP = 4,
    parameter int ADDR_W  = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cfg_wr_en,
    input  logic [ADDR_W-1:0]  cfg_addr,
    input  logic [31:0]        cfg_wdata,
    output logic [31:0]        cfg_rdata,
    input  logic [31:0]        fetch_addr,
    output logic               bp_hit,
    output logic [NUM_CMP-1:0] bp_hit_vec
);
    localparam int WIX_W = ADDR_W - 2;

    logic [WIX_W-1:0]   word_ix;
    logic               ctrl_sel;
    logic               glob_en;
    logic [31:0]        ctrl_rdata;
    logic [NUM_CMP-1:0] slot_sel;
    logic [NUM_CMP-1:0] slot_match;
    logic [31:0]        slot_rdata [NUM_CMP];
    logic               unused_low;

    assign unused_low = ^{cfg_addr[1:0]};
    assign word_ix    = cfg_addr[ADDR_W-1:2];
    assign ctrl_sel   = (word_ix == WIX_W'(CTRL_WORD_IX));

    hbp_global_ctl #(.NUM_CMP(NUM_CMP)) u_ctl (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (cfg_wr_en && ctrl_sel),
        .wdata   (cfg_wdata),
        .glob_en (glob_en),
        .rdata   (ctrl_rdata)
    );

    for (genvar k = 0; k < NUM_CMP; k++) begin : g_slot
        assign slot_sel[k] = (word_ix == WIX_W'(SLOT_WORD_IX + k));

        hbp_slot u_slot (
            .clk        (clk),
            .rst_n      (rst_n),
            .wr_en      (cfg_wr_en && slot_sel[k]),
            .wdata      (cfg_wdata),
            .glob_en    (glob_en),
            .fetch_addr (fetch_addr),
            .rdata      (slot_rdata[k]),
            .match      (slot_match[k])
        );
    end

    always_comb begin
        cfg_rdata = ctrl_sel ? ctrl_rdata : 32'h0;
        for (int k = 0; k < NUM_CMP; k++) begin
            if (slot_sel[k]) cfg_rdata = cfg_rdata | slot_rdata[k];
        end
    end

    hbp_hit_pick #(.NUM_CMP(NUM_CMP)) u_pick (
        .clk     (clk),
        .rst_n   (rst_n),
        .match   (slot_match),
        .hit     (bp_hit),
        .hit_vec (bp_hit_vec)
    );

endmodule

// File: rtl/halfword_bp_unit_chk.sv
module halfword_bp_unit_chk #(
    parameter int NUM_CMP = 4,
    parameter int ADDR_W  = 8
) (
    input logic               clk,
    input logic               rst_n,
    input logic               cfg_wr_en,
    input logic [ADDR_W-1:0]  cfg_addr,
    input logic [31:0]        cfg_wdata,
    input logic [31:0]        cfg_rdata,
    input logic [31:0]        fetch_addr,
    input logic               bp_hit,
    input logic [NUM_CMP-1:0] bp_hit_vec,
    input logic               glob_en
);
    localparam logic [3:0] CNT_FIELD = NUM_CMP[3:0];

    logic ctrl_addr;
    assign ctrl_addr = (cfg_addr[ADDR_W-1:2] == '0);

    AST_VEC_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(bp_hit_vec)); // R9

    AST_HIT_AGREES_VEC: assert property (@(posedge clk) disable iff (!rst_n)
        bp_hit == (bp_hit_vec != '0)); // R8

    AST_HIGH_ADDR_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (fetch_addr[31:29] != 3'b000) |=> !bp_hit); // R6

    AST_DISABLED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !glob_en |=> !bp_hit); // R7

    AST_KEY_GUARD: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_wr_en && ctrl_addr && !cfg_wdata[1]) |=> $stable(glob_en)); // R2

    AST_CTRL_READBACK: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_addr |-> (cfg_rdata[1] == 1'b0 && cfg_rdata[7:4] == CNT_FIELD)); // R1

endmodule

bind halfword_bp_unit halfword_bp_unit_chk #(.NUM_CMP(NUM_CMP), .ADDR_W(ADDR_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cfg_wr_en  (cfg_wr_en),
    .cfg_addr   (cfg_addr),
    .cfg_wdata  (cfg_wdata),
    .cfg_rdata  (cfg_rdata),
    .fetch_addr (fetch_addr),
    .bp_hit     (bp_hit),
    .bp_hit_vec (bp_hit_vec),
    .glob_en    (glob_en)
);

// File: tb/halfword_bp_unit_bench.sv
module halfword_bp_unit_bench;
    localparam int N = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_wr_en = 1'b0;
    logic [7:0]  cfg_addr = '0;
    logic [31:0] cfg_wdata = '0;
    logic [31:0] cfg_rdata;
    logic [31:0] fetch_addr = '0;
    logic        bp_hit;
    logic [N-1:0] bp_hit_vec;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    halfword_bp_unit #(.NUM_CMP(N), .ADDR_W(8)) u_halfword_bp_unit (
        .clk(clk), .rst_n(rst_n), .cfg_wr_en(cfg_wr_en), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .fetch_addr(fetch_addr),
        .bp_hit(bp_hit), .bp_hit_vec(bp_hit_vec)
    );

    // {fetch address, expected hit, expected one-hot vector}
    localparam logic [36:0] VECS [0:8] = '{
        {32'h0000_0100, 1'b1, 4'b0001},  // R9: slots 0 and 1 both match, lowest wins
        {32'h0000_0102, 1'b1, 4'b0010},  // R5: upper half, only selector 11 matches
        {32'h0000_0104, 1'b0, 4'b0000},  // R5: no slot holds this word
        {32'h1FFF_FFFC, 1'b0, 4'b0000},  // R5: selector 10 ignores lower half
        {32'h1FFF_FFFE, 1'b1, 4'b0100},  // R5: selector 10 on upper half
        {32'h0000_2000, 1'b0, 4'b0000},  // R5: selector 00 never matches
        {32'h2000_0100, 1'b0, 4'b0000},  // R6: bit 29 set
        {32'hE000_0102, 1'b0, 4'b0000},  // R6: top bits set
        {32'h0000_0101, 1'b1, 4'b0001}   // R5: fetch bit 0 ignored
    };

    task automatic check32(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
        end
    endtask

    task automatic cfg_write(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        cfg_wr_en = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk);
        cfg_wr_en = 1'b0;
    endtask

    task automatic cfg_read(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        cfg_addr = a;
        #1 d = cfg_rdata;
    endtask

    task automatic fetch_check(input logic [31:0] fa, input logic h, input logic [N-1:0] v, input string tag);
        @(negedge clk);
        fetch_addr = fa;
        @(negedge clk);
        check32({tag, " hit"}, {31'b0, bp_hit}, {31'b0, h});
        check32({tag, " vec"}, {28'b0, bp_hit_vec}, {28'b0, v});
    endtask

    task automatic summary;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    endtask

    initial begin
        logic [31:0] rd;
        repeat (3) @(negedge clk);
        // R3 reset state
        check32("R3 hit at reset", {31'b0, bp_hit}, 32'h0);
        check32("R3 vec at reset", {28'b0, bp_hit_vec}, 32'h0);
        cfg_read(8'h00, rd); check32("R3 ctrl at reset", rd, 32'h0000_0040);
        for (int k = 0; k < N; k++) begin
            cfg_read(8'(8 + 4 * k), rd); check32("R3 slot word at reset", rd, 32'h0);
        end
        rst_n = 1'b1;

        // R1 / R2 keyed control
        cfg_write(8'h00, 32'h0000_0001);
        cfg_read(8'h00, rd); check32("R2 keyless enable ignored", rd, 32'h0000_0040);
        cfg_write(8'h00, 32'hFFFF_FFFF);
        cfg_read(8'h00, rd); check32("R1 ctrl readback enabled", rd, 32'h0000_0041);

        // R4 slot programming and readback
        cfg_write(8'h08, 32'hE000_0103);
        cfg_read(8'h08, rd); check32("R4 bits 29 and 1 read zero", rd, 32'hC000_0101);
        cfg_write(8'h08, 32'h4000_0101);
        cfg_write(8'h0C, 32'hC000_0101);
        cfg_write(8'h10, 32'h9FFF_FFFD);
        cfg_write(8'h14, 32'h0000_2001);
        cfg_read(8'h10, rd); check32("R4 slot 2 readback", rd, 32'h9FFF_FFFD);

        // vector table
        for (int i = 0; i < 9; i++) begin
            fetch_check(VECS[i][36:5], VECS[i][4], VECS[i][3:0],
                        $sformatf("R5 R6 R9 vector %0d", i));
        end

        // R8 latency: output unchanged before the edge, updated after it
        fetch_check(32'h0000_0104, 1'b0, 4'b0000, "R8 idle");
        @(negedge clk);
        fetch_addr = 32'h0000_0100;
        #1 check32("R8 no hit before edge", {31'b0, bp_hit}, 32'h0);
        @(negedge clk);
        check32("R8 hit after one edge", {31'b0, bp_hit}, 32'h1);

        // R2 keyless disable ignored, hit persists
        cfg_write(8'h00, 32'h0000_0000);
        cfg_read(8'h00, rd); check32("R2 keyless disable ignored", rd, 32'h0000_0041);
        fetch_check(32'h0000_0100, 1'b1, 4'b0001, "R2 still hitting");

        // R7 global disable
        cfg_write(8'h00, 32'h0000_0002);
        fetch_check(32'h0000_0100, 1'b0, 4'b0000, "R7 global off");
        cfg_write(8'h00, 32'h0000_0003);
        // R7 slot enable cleared
        cfg_write(8'h08, 32'h4000_0100);
        fetch_check(32'h0000_0100, 1'b1, 4'b0010, "R7 slot 0 off, slot 1 remains");
        cfg_write(8'h0C, 32'hC000_0100);
        fetch_check(32'h0000_0100, 1'b0, 4'b0000, "R7 both slots off");

        // R10 unimplemented offsets
        cfg_write(8'h18, 32'hC000_0105);
        cfg_read(8'h18, rd); check32("R10 beyond count reads zero", rd, 32'h0);
        cfg_write(8'h04, 32'hFFFF_FFFF);
        cfg_read(8'h04, rd); check32("R10 offset 0x4 reads zero", rd, 32'h0);
        cfg_read(8'h14, rd); check32("R10 last slot untouched", rd, 32'h0000_2001);
        fetch_check(32'h0000_0104, 1'b0, 4'b0000, "R10 ignored slot never hits");

        done = 1'b1;
        summary();
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog R8: actual timeout expected completion");
            summary();
            $finish;
        end
    end

endmodule